// File: doc/BRIEF.md
# LIN Slave Frame and Sleep Controller

This block is the frame-level half of a LIN slave node that programs a two-register routing table. A separate bit-level receiver hands it already-deframed events: a break pulse, received bytes with a one-cycle valid strobe, a pulse when the sync field timing is out of tolerance, and a pulse when a byte read back from the bus differs from the byte the node sent. The controller checks the protected identifier, takes in routing writes, answers status reads, and verifies every checksum. It keeps a sticky error register.

A pin-driven selector picks one of three identifier pairs, so three nodes can share a bus. A read answer holds the error register, both routing registers, a constant stuffing byte and a checksum. The answer is paced by its own readback: each byte is handed to the transmitter only after the previous one has come back on the receive side.

A sleep sequencer drives the external transceiver's active-low sleep line and the transmit enable. Both start inactive. The sequencer wakes on a falling edge of the receive line. It falls asleep after a programmable stretch of bus silence, or on the standard sleep command frame.

Top module: `lin_slave_ctrl`

## Requirements
- R1: After reset both routing registers and the error register read 0x00, `sleep_n_o` and `tx_en_o` are low, and `tx_valid_o` is low.
- R2: A one-cycle pulse on `rxd_fall_i` drives `sleep_n_o` and `tx_en_o` high at the following clock edge. While asleep, breaks, received bytes and both error pulses have no effect on any register.
- R3: A frame is a break, a sync byte whose value is not inspected, and a protected identifier byte. The identifier byte is ID in bits 5:0, P0 in bit 6 and P1 in bit 7, with P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). A parity mismatch sets error bit 1 and the frame is dropped.
- R4: `id_sel_i` = 0 selects write/read identifier bytes 0x08/0xE7, 1 selects 0xCA/0xE9, and 2 or 3 selects 0x9C/0x2B. A correctly protected identifier that is neither member of the selected pair nor 0x3C is ignored.
- R5: A write frame is the write identifier, a byte for `route0_o`, a byte for `route1_o`, and a checksum. Both routing outputs take the new values at the edge that samples a correct checksum.
- R6: The checksum is the bitwise inverse of the 8-bit sum of the data bytes with end-around carry (for example 0xF0, 0x35 gives 0xD9). On a mismatch error bit 2 is set and the routing registers keep their values.
- R7: After the read identifier, `tx_valid_o` pulses with, in turn, the error register, `route0_o`, `route1_o`, 0xFF and the checksum of those four bytes. The first byte follows the identifier's strobe by one cycle, and each later byte follows the strobe of the previous byte's readback by one cycle.
- R8: When the readback of the fifth response byte arrives with no mismatch, the error register clears to 0x00.
- R9: A pulse on `rb_mismatch_i` sets error bit 3. During a read response it also ends the response: nothing more is sent and the register is not cleared.
- R10: A pulse on `sync_err_i` sets error bit 4. Error bits 7:5 always read 0.
- R11: If a frame has not completed `FRAME_CYC` cycles after the edge that sampled its break, error bit 0 is set at that edge and the frame is dropped.
- R12: When `IDLE_CYC` clock edges pass with no break, byte strobe or receive falling edge, `sleep_n_o` and `tx_en_o` go low.
- R13: A frame with identifier byte 0x3C, data 0x00 then seven 0xFF, and a correct checksum (0x00) drives `sleep_n_o` and `tx_en_o` low at the checksum edge. Any other data leaves the node awake.
- R14: A break in the middle of a frame discards the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| brk_i | input | 1 | One-cycle break detected pulse |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| sync_err_i | input | 1 | Sync field out of tolerance pulse |
| rb_mismatch_i | input | 1 | Readback differs from sent byte pulse |
| rxd_fall_i | input | 1 | Falling edge seen on the receive line |
| id_sel_i | input | 2 | Identifier pair select |
| tx_valid_o | output | 1 | Byte to transmit strobe |
| tx_byte_o | output | 8 | Byte to transmit |
| route0_o | output | 8 | Routing register 0 |
| route1_o | output | 8 | Routing register 1 |
| err_flags_o | output | 8 | Sticky error register |
| sleep_n_o | output | 1 | Transceiver sleep line, low means sleep |
| tx_en_o | output | 1 | Transmit enable |

## Verification
Every result is registered once, so each one is due at the first edge after the stimulus that causes it. The routing update, the error bits, each response byte and the sleep entry on a command frame all land at the edge that samples the triggering strobe. The bench drives inputs on the falling clock edge and samples the outputs at the next falling edge, which is half a cycle after the edge that produces them. The two timeouts are checked one cycle before and at their due edge, counted from the edge that sampled the break or the wake pulse.

// File: rtl/lin_slv_pkg.sv
package lin_slv_pkg;

    localparam int BYTE_W     = 8;
    localparam int ID_W       = 6;
    localparam int IDX_W      = 4;

    localparam logic [IDX_W-1:0] WR_BYTES   = 4'd2;
    localparam logic [IDX_W-1:0] SLP_BYTES  = 4'd8;
    localparam logic [IDX_W-1:0] RESP_BYTES = 4'd4;

    localparam logic [ID_W-1:0]   SLEEP_ID  = 6'h3C;
    localparam logic [BYTE_W-1:0] STUFF_B   = 8'hFF;
    localparam logic [BYTE_W-1:0] SLP_FIRST = 8'h00;
    localparam logic [BYTE_W-1:0] SLP_FILL  = 8'hFF;

    // error register bit positions
    localparam int EB_TMO  = 0;
    localparam int EB_PAR  = 1;
    localparam int EB_CSUM = 2;
    localparam int EB_RDBK = 3;
    localparam int EB_SYNC = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SYNC  = 3'd1,
        ST_PID   = 3'd2,
        ST_RXDAT = 3'd3,
        ST_RESP  = 3'd4
    } frm_st_e;

    typedef struct packed {
        frm_st_e            st;
        logic               is_slp;
        logic [IDX_W-1:0]   idx;
        logic [BYTE_W-1:0]  sum;
        logic [BYTE_W-1:0]  hold0;
        logic [BYTE_W-1:0]  hold1;
        logic               slp_ok;
        logic [BYTE_W-1:0]  rt0;
        logic [BYTE_W-1:0]  rt1;
        logic [BYTE_W-1:0]  err;
        logic [BYTE_W-1:0]  txb;
        logic               txv;
    } frm_regs_t;

    // 8-bit add with end-around carry
    function automatic logic [BYTE_W-1:0] csum_add(input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
    endfunction

    // parity pair {P1, P0} for a 6-bit identifier
    function automatic logic [1:0] pid_par(input logic [ID_W-1:0] id);
        return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
    endfunction

endpackage

// File: rtl/lin_pid_decode.sv
module lin_pid_decode
    import lin_slv_pkg::*;
(
    input  logic [BYTE_W-1:0] pid_i,
    input  logic [1:0]        sel_i,
    output logic              par_ok_o,
    output logic              wr_hit_o,
    output logic              rd_hit_o,
    output logic              slp_hit_o
);
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] wr_id;
    logic [ID_W-1:0] rd_id;

    assign id = pid_i[ID_W-1:0];

    // R4: identifier pair per selector value
    always_comb begin
        case (sel_i)
            2'd0:    begin wr_id = 6'h08; rd_id = 6'h27; end
            2'd1:    begin wr_id = 6'h0A; rd_id = 6'h29; end
            default: begin wr_id = 6'h1C; rd_id = 6'h2B; end
        endcase
    end

    // R3: parity bits in 7:6
    assign par_ok_o  = (pid_i[BYTE_W-1:ID_W] == pid_par(id));
    assign wr_hit_o  = par_ok_o && (id == wr_id);
    assign rd_hit_o  = par_ok_o && (id == rd_id);
    assign slp_hit_o = par_ok_o && (id == SLEEP_ID);
endmodule

// File: rtl/lin_frame_timer.sv
module lin_frame_timer #(
    parameter int LIMIT = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    // R11: cycles since the break edge while a frame is open
    always_comb begin
        if (restart_i || !run_i) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
        expired_o = run_i && !restart_i && (cnt_q == LAST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lin_sleep_ctl.sv
module lin_sleep_ctl #(
    parameter int IDLE_CYC = 60000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    input  logic activity_i,
    input  logic sleep_cmd_i,
    output logic awake_o
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

    logic          awake_d, awake_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        awake_d = awake_q;
        cnt_d   = cnt_q;
        if (!awake_q) begin
            cnt_d = '0;
            if (wake_i) awake_d = 1'b1;          // R2
        end else if (sleep_cmd_i) begin
            awake_d = 1'b0;                      // R13
            cnt_d   = '0;
        end else if (activity_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            awake_d = 1'b0;                      // R12
            cnt_d   = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            awake_q <= 1'b0;                     // R1
            cnt_q   <= '0;
        end else begin
            awake_q <= awake_d;
            cnt_q   <= cnt_d;
        end
    end

    assign awake_o = awake_q;
endmodule

// File: rtl/lin_slave_ctrl.sv
module lin_slave_ctrl
    import lin_slv_pkg::*;
#(
    parameter int FRAME_CYC = 200000,
    parameter int IDLE_CYC  = 60000000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              brk_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              sync_err_i,
    input  logic              rb_mismatch_i,
    input  logic              rxd_fall_i,
    input  logic [1:0]        id_sel_i,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic [BYTE_W-1:0] route0_o,
    output logic [BYTE_W-1:0] route1_o,
    output logic [BYTE_W-1:0] err_flags_o,
    output logic              sleep_n_o,
    output logic              tx_en_o
);
    frm_regs_t d, q;

    logic              awake;
    logic              sleep_cmd;
    logic              tmo_exp;
    logic              par_ok, wr_hit, rd_hit, slp_hit;
    logic [IDX_W-1:0]  need;
    logic [IDX_W-1:0]  nxt_idx;
    logic [BYTE_W-1:0] resp_b;

    lin_pid_decode u_pid (
        .pid_i     (rx_byte_i),
        .sel_i     (id_sel_i),
        .par_ok_o  (par_ok),
        .wr_hit_o  (wr_hit),
        .rd_hit_o  (rd_hit),
        .slp_hit_o (slp_hit)
    );

    lin_frame_timer #(.LIMIT(FRAME_CYC)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (brk_i && awake),
        .run_i     (q.st != ST_IDLE),
        .expired_o (tmo_exp)
    );

    lin_sleep_ctl #(.IDLE_CYC(IDLE_CYC)) u_slp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wake_i      (rxd_fall_i),
        .activity_i  (brk_i || rx_valid_i || rxd_fall_i),
        .sleep_cmd_i (sleep_cmd),
        .awake_o     (awake)
    );

    assign need    = q.is_slp ? SLP_BYTES : WR_BYTES;
    assign nxt_idx = q.idx + 4'd1;

    // R7: response byte order after the error register
    always_comb begin
        case (nxt_idx)
            4'd1:    resp_b = q.rt0;
            4'd2:    resp_b = q.rt1;
            default: resp_b = STUFF_B;
        endcase
    end

    always_comb begin
        d         = q;
        d.txv     = 1'b0;
        sleep_cmd = 1'b0;
        if (!awake) begin
            d.st = ST_IDLE;                                  // R2
        end else begin
            if (rx_valid_i) begin
                case (q.st)
                    ST_SYNC: d.st = ST_PID;
                    ST_PID: begin
                        d.idx    = '0;
                        d.sum    = '0;
                        d.slp_ok = 1'b1;
                        if (!par_ok) begin
                            d.err[EB_PAR] = 1'b1;            // R3
                            d.st          = ST_IDLE;
                        end else if (wr_hit) begin
                            d.st     = ST_RXDAT;
                            d.is_slp = 1'b0;
                        end else if (slp_hit) begin
                            d.st     = ST_RXDAT;
                            d.is_slp = 1'b1;
                        end else if (rd_hit) begin
                            d.st  = ST_RESP;                 // R7
                            d.txb = q.err;
                            d.txv = 1'b1;
                            d.sum = q.err;
                        end else begin
                            d.st = ST_IDLE;                  // R4
                        end
                    end
                    ST_RXDAT: begin
                        if (q.idx < need) begin
                            d.sum = csum_add(q.sum, rx_byte_i);
                            d.idx = nxt_idx;
                            if (q.idx == '0) begin
                                d.hold0  = rx_byte_i;
                                d.slp_ok = (rx_byte_i == SLP_FIRST);
                            end else begin
                                d.slp_ok = q.slp_ok && (rx_byte_i == SLP_FILL);
                            end
                            if (q.idx == 4'd1) d.hold1 = rx_byte_i;
                        end else begin
                            d.st = ST_IDLE;
                            if (rx_byte_i == ~q.sum) begin   // R6
                                if (q.is_slp) begin
                                    sleep_cmd = q.slp_ok;    // R13
                                end else begin
                                    d.rt0 = q.hold0;         // R5
                                    d.rt1 = q.hold1;
                                end
                            end else begin
                                d.err[EB_CSUM] = 1'b1;
                            end
                        end
                    end
                    ST_RESP: begin
                        if (q.idx == RESP_BYTES) begin
                            d.st = ST_IDLE;
                            if (!rb_mismatch_i) d.err = '0;  // R8
                        end else begin
                            d.idx = nxt_idx;
                            d.txv = 1'b1;
                            if (nxt_idx < RESP_BYTES) begin
                                d.txb = resp_b;
                                d.sum = csum_add(q.sum, resp_b);
                            end else begin
                                d.txb = ~q.sum;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (tmo_exp) begin
                d.err[EB_TMO] = 1'b1;                        // R11
                d.st          = ST_IDLE;
                d.txv         = 1'b0;
            end
            if (sync_err_i) d.err[EB_SYNC] = 1'b1;           // R10
            if (rb_mismatch_i) begin
                d.err[EB_RDBK] = 1'b1;                       // R9
                if (q.st == ST_RESP) begin
                    d.st  = ST_IDLE;
                    d.txv = 1'b0;
                end
            end
            if (brk_i) begin
                d.st  = ST_SYNC;                             // R14
                d.txv = 1'b0;
            end
        end
        d.err[BYTE_W-1:EB_SYNC+1] = '0;
    end

    // reset value: ST_IDLE is code 0, all fields cleared (R1)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tx_valid_o  = q.txv;
    assign tx_byte_o   = q.txb;
    assign route0_o    = q.rt0;
    assign route1_o    = q.rt1;
    assign err_flags_o = q.err;
    assign sleep_n_o   = awake;
    assign tx_en_o     = awake;
endmodule

// File: rtl/lin_slave_ctrl_chk.sv
module lin_slave_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rx_valid_i,
    input logic       rxd_fall_i,
    input logic       tx_valid_o,
    input logic [7:0] route0_o,
    input logic [7:0] route1_o,
    input logic [7:0] err_flags_o,
    input logic       sleep_n_o
);
    // R10
    err_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_flags_o[7:5] == 3'b000);

    // R2
    wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sleep_n_o) |-> $past(rxd_fall_i));

    // R7
    tx_after_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |-> $past(rx_valid_i));

    // R2
    no_tx_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_n_o |-> !tx_valid_o);

    // R5
    route0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(route0_o) |-> $past(rx_valid_i));

    // R5
    route1_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(route1_o) |-> $past(rx_valid_i));

    // R3
    par_flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_flags_o[1]) |-> $past(rx_valid_i));
endmodule

bind lin_slave_ctrl lin_slave_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rxd_fall_i  (rxd_fall_i),
    .tx_valid_o  (tx_valid_o),
    .route0_o    (route0_o),
    .route1_o    (route1_o),
    .err_flags_o (err_flags_o),
    .sleep_n_o   (sleep_n_o)
);

// File: tb/tb_lin_slave_ctrl.sv
module tb_lin_slave_ctrl;
    localparam int FRAME_CYC = 120;
    localparam int IDLE_CYC  = 300;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       brk, rxv, serr, rbm, rxf;
    logic [7:0] rxb;
    logic [1:0] idsel;
    logic       tx_valid_o, sleep_n_o, tx_en_o;
    logic [7:0] tx_byte_o, route0_o, route1_o, err_flags_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic       last_txv;
    logic [7:0] last_txb;
    logic [7:0] exp_err, exp_r0, exp_r1;

    always #10 clk = ~clk;

    lin_slave_ctrl #(.FRAME_CYC(FRAME_CYC), .IDLE_CYC(IDLE_CYC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .rx_valid_i(rxv), .rx_byte_i(rxb),
        .sync_err_i(serr), .rb_mismatch_i(rbm), .rxd_fall_i(rxf), .id_sel_i(idsel),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .route0_o(route0_o),
        .route1_o(route1_o), .err_flags_o(err_flags_o), .sleep_n_o(sleep_n_o),
        .tx_en_o(tx_en_o)
    );

    function automatic logic [7:0] m_add(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 255;
        return 8'(s);
    endfunction

    function automatic logic [7:0] m_pid(input logic [5:0] id);
        logic p0, p1;
        p0 = ^(id & 6'b010111);
        p1 = ~(^(id & 6'b111010));
        return {p1, p0, id};
    endfunction

    function automatic logic [7:0] rd_pid(input logic [1:0] s);
        case (s)
            2'd0:    return 8'hE7;
            2'd1:    return 8'hE9;
            default: return 8'h2B;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_brk();
        brk = 1'b1;
        @(negedge clk);
        brk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic mm);
        rxv = 1'b1; rxb = b; rbm = mm;
        @(negedge clk);
        last_txv = tx_valid_o;
        last_txb = tx_byte_o;
        rxv = 1'b0; rbm = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wake();
        rxf = 1'b1;
        @(negedge clk);
        rxf = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] pid, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] c);
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(pid, 1'b0);
        send_byte(a, 1'b0);
        send_byte(b, 1'b0);
        send_byte(c, 1'b0);
    endtask

    task automatic do_read(input logic [7:0] pid);
        logic [7:0] e [5];
        logic [7:0] echo;
        e[0] = exp_err; e[1] = exp_r0; e[2] = exp_r1; e[3] = 8'hFF;
        e[4] = ~m_add(m_add(m_add(e[0], e[1]), e[2]), e[3]);
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(pid, 1'b0);
        chk("R7 first byte strobe", last_txv, 1);
        chk("R7 first byte value", last_txb, e[0]);
        for (int i = 0; i < 5; i++) begin
            echo = last_txb;
            send_byte(echo, 1'b0);
            if (i < 4) begin
                chk("R7 next byte strobe", last_txv, 1);
                chk("R7 next byte value", last_txb, e[i+1]);
            end else begin
                chk("R7 no byte after checksum", last_txv, 0);
            end
        end
        chk("R8 errors cleared after read", err_flags_o, 0);
        exp_err = 8'h00;
    endtask

    initial begin
        brk = 0; rxv = 0; rxb = 0; serr = 0; rbm = 0; rxf = 0; idsel = 0; rst_n = 0;
        last_txv = 0; last_txb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 route0 reset", route0_o, 0);
        chk("R1 route1 reset", route1_o, 0);
        chk("R1 err reset", err_flags_o, 0);
        chk("R1 sleep_n reset", sleep_n_o, 0);
        chk("R1 tx_en reset", tx_en_o, 0);
        chk("R1 tx_valid reset", tx_valid_o, 0);

        // R2 frames and pulses while asleep are ignored
        do_write(8'h08, 8'h11, 8'h22, ~m_add(8'h11, 8'h22));
        serr = 1'b1; @(negedge clk); serr = 1'b0;
        chk("R2 asleep route0", route0_o, 0);
        chk("R2 asleep route1", route1_o, 0);
        chk("R2 asleep err", err_flags_o, 0);
        chk("R2 still asleep", sleep_n_o, 0);
        wake();
        chk("R2 wake sleep_n", sleep_n_o, 1);
        chk("R2 wake tx_en", tx_en_o, 1);

        // R3 R4 sweep of every identifier byte under every selector value
        exp_err = 8'h00; exp_r0 = 8'h00; exp_r1 = 8'h00;
        for (int s = 0; s < 4; s++) begin
            idsel = 2'(s);
            for (int p = 0; p < 256; p++) begin
                logic good, is_rd;
                send_brk();
                send_byte(8'h55, 1'b0);
                send_byte(8'(p), 1'b0);
                good  = (m_pid(6'(p)) == 8'(p));
                is_rd = good && (8'(p) == rd_pid(2'(s)));
                if (!good) exp_err[1] = 1'b1;
                chk("R3 parity error flag", err_flags_o, exp_err);
                chk("R4 read identifier answered", last_txv, is_rd);
            end
        end
        idsel = 2'd0;

        // R7 R8 read with parity flag pending
        do_read(8'hE7);

        // R5 write
        do_write(8'h08, 8'h5A, 8'hC3, ~m_add(8'h5A, 8'hC3));
        chk("R5 route0 written", route0_o, 8'h5A);
        chk("R5 route1 written", route1_o, 8'hC3);

        // R6 end-around carry checksum
        do_write(8'h08, 8'hF0, 8'h35, 8'hD9);
        chk("R6 carry route0", route0_o, 8'hF0);
        chk("R6 carry route1", route1_o, 8'h35);
        exp_r0 = 8'hF0; exp_r1 = 8'h35;

        // R6 bad checksum
        do_write(8'h08, 8'h11, 8'h22, ~m_add(8'h11, 8'h22) ^ 8'h01);
        chk("R6 bad csum route0 kept", route0_o, 8'hF0);
        chk("R6 bad csum route1 kept", route1_o, 8'h35);
        exp_err = 8'h04;
        chk("R6 bad csum flag", err_flags_o, exp_err);

        // R7 R8 read carrying routes and a flag
        do_read(8'hE7);

        // R4 other identifier pairs
        idsel = 2'd1;
        do_write(8'hCA, 8'h01, 8'h80, ~m_add(8'h01, 8'h80));
        chk("R4 pair1 route0", route0_o, 8'h01);
        chk("R4 pair1 route1", route1_o, 8'h80);
        exp_r0 = 8'h01; exp_r1 = 8'h80;
        idsel = 2'd2;
        do_write(8'h08, 8'h77, 8'h66, ~m_add(8'h77, 8'h66));
        chk("R4 foreign write ignored", route0_o, 8'h01);
        do_read(8'h2B);
        idsel = 2'd3;
        do_write(8'h9C, 8'hFF, 8'hFF, ~m_add(8'hFF, 8'hFF));
        chk("R4 pair2 via code 3 route0", route0_o, 8'hFF);
        chk("R4 pair2 via code 3 route1", route1_o, 8'hFF);
        exp_r0 = 8'hFF; exp_r1 = 8'hFF;
        idsel = 2'd0;

        // R9 readback mismatch aborts the answer
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(8'hE7, 1'b0);
        send_byte(last_txb, 1'b0);
        chk("R9 second byte sent", last_txv, 1);
        send_byte(last_txb, 1'b1);
        chk("R9 abort no byte", last_txv, 0);
        send_byte(8'hFF, 1'b0);
        chk("R9 stays aborted", last_txv, 0);
        exp_err = 8'h08;
        chk("R9 readback flag", err_flags_o, exp_err);

        // R10 sync tolerance flag
        serr = 1'b1; @(negedge clk); serr = 1'b0;
        exp_err = 8'h18;
        chk("R10 sync flag", err_flags_o, exp_err);
        chk("R10 top bits zero", err_flags_o[7:5], 0);

        // R14 break mid-frame restarts
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(8'h08, 1'b0);
        send_byte(8'hAA, 1'b0);
        do_write(8'h08, 8'h12, 8'h34, ~m_add(8'h12, 8'h34));
        chk("R14 restart route0", route0_o, 8'h12);
        chk("R14 restart route1", route1_o, 8'h34);

        // R11 frame timeout
        send_brk();
        repeat (FRAME_CYC - 1) @(negedge clk);
        chk("R11 no timeout yet", err_flags_o[0], 0);
        @(negedge clk);
        chk("R11 timeout flag", err_flags_o[0], 1);

        // R13 sleep frame with wrong data keeps node awake
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h00, 1'b0);
        for (int i = 0; i < 5; i++) send_byte(8'hFF, 1'b0);
        send_byte(8'hFE, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(~m_add(8'hFE, 8'hFF), 1'b0);
        chk("R13 wrong data stays awake", sleep_n_o, 1);

        // R13 correct sleep frame
        send_brk();
        send_byte(8'h55, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h00, 1'b0);
        for (int i = 0; i < 7; i++) send_byte(8'hFF, 1'b0);
        send_byte(8'h00, 1'b0);
        chk("R13 sleep_n low", sleep_n_o, 0);
        chk("R13 tx_en low", tx_en_o, 0);

        // R12 inactivity timeout
        wake();
        repeat (IDLE_CYC - 1) @(negedge clk);
        chk("R12 awake before timeout", sleep_n_o, 1);
        @(negedge clk);
        chk("R12 sleep_n after timeout", sleep_n_o, 0);
        chk("R12 tx_en after timeout", tx_en_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule